// File: doc/BRIEF.md
# Variable-Range Memory Type Resolver

This block keeps a small bank of programmable range descriptors. Each descriptor pairs a base register with a mask register, and together they map an aligned, power-of-two sized region of physical memory to a caching type. The regions are 4 KByte in size or larger. Software programs the descriptors through a single register write port and can read any register back through a read port.

A physical address on the lookup port is compared with every enabled descriptor at once. The hits are merged into one memory type, and that type is returned together with a hit flag and an overlap-error flag. All three appear on registered outputs one clock after the address is sampled.

The physical address width is a parameter, for example 36 or 40 bits. The width of the base and mask fields follows it.

Top module: `vr_memtype_resolver`

## Requirements
- R1: A lookup address hits a descriptor when the descriptor's valid bit is set and the address equals the stored base over every bit position from 12 up to PA_WIDTH-1 where the stored mask holds a one. The first byte and the last byte of the region therefore hit, and the byte just past the region misses.
- R2: Type codes are 8'h00 for uncacheable (UC), 8'h01 for write-combining (WC), 8'h04 for write-through (WT) and 8'h06 for write-back (WB). When exactly one descriptor hits, the output carries that descriptor's type, and hit_o is 1.
- R3: When any hitting descriptor is UC, the result is UC, hit_o is 1 and conflict_o is 0, whatever the other hits are.
- R4: When several descriptors hit and all of them carry the same type, the result is that type. When the hits are a mix of WB and WT only, the result is WT. In both cases conflict_o is 0.
- R5: Any other mix of hitting types drives type 8'h00 (UC) with hit_o=1 and conflict_o=1.
- R6: When no descriptor hits, hit_o=0, conflict_o=0 and the type output equals the DEFAULT_TYPE parameter.
- R7: Register layout, with wr_sel_mask_i/rd_sel_mask_i set to 0 for the base and 1 for the mask. In the base register, bits [PA_WIDTH-1:12] hold the region base and bits [7:0] hold the type. In the mask register, bits [PA_WIDTH-1:12] hold the mask and bit 11 is the valid bit. All other bits are ignored on write and read back as zero. A write to an index of NUM_PAIRS or above has no effect.
- R8: The type, hit and conflict outputs reflect the address presented at the previous rising clock edge, one cycle of latency.
- R9: Asynchronous reset clears all descriptor registers, including every valid bit, and sets the outputs to hit_o=0, conflict_o=0 and the type to DEFAULT_TYPE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | IDX_W | Descriptor index for the write |
| wr_sel_mask_i | input | 1 | Write target: 0 for base, 1 for mask |
| wr_data_i | input | 64 | Write data |
| rd_idx_i | input | IDX_W | Descriptor index for the readback |
| rd_sel_mask_i | input | 1 | Readback target: 0 for base, 1 for mask |
| rd_data_o | output | 64 | Readback data (combinational) |
| lk_addr_i | input | PA_WIDTH | Lookup physical address |
| mem_type_o | output | 8 | Resolved memory type (registered) |
| hit_o | output | 1 | At least one enabled descriptor matched (registered) |
| conflict_o | output | 1 | Hitting types cannot be merged (registered) |

## Verification
Corruption in a descriptor register shows up as soon as that register is read back. It also shows up on the first lookup whose address falls on a region edge: a base or mask bit that is flipped moves or resizes the region. A fault in the merge logic shows up only where regions overlap. For that reason the sweeps cover the UC carve-out inside a WB region, a WB/WT overlap and a WC/WB overlap. Every wrong result is visible one cycle after the address is presented, because the output stage holds no other state.

// File: rtl/vr_mt_pkg.sv
package vr_mt_pkg;
  typedef logic [7:0] mtype_t;
  localparam mtype_t MT_UC = 8'h00;
  localparam mtype_t MT_WC = 8'h01;
  localparam mtype_t MT_WT = 8'h04;
  localparam mtype_t MT_WB = 8'h06;
  localparam int unsigned PAGE_LSB  = 12;
  localparam int unsigned VALID_BIT = 11;
endpackage

// File: rtl/vr_pair_regs.sv
module vr_pair_regs
  import vr_mt_pkg::*;
#(
  parameter int unsigned PA_WIDTH  = 36,
  parameter int unsigned NUM_PAIRS = 6,
  parameter int unsigned IDX_W     = 3,
  localparam int unsigned FW       = PA_WIDTH - PAGE_LSB
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic                           wr_sel_mask_i,
  input  logic [63:0]                    wr_data_i,
  input  logic [IDX_W-1:0]               rd_idx_i,
  input  logic                           rd_sel_mask_i,
  output logic [63:0]                    rd_data_o,
  output logic [NUM_PAIRS-1:0][FW-1:0]   base_o,
  output logic [NUM_PAIRS-1:0][FW-1:0]   mask_o,
  output mtype_t [NUM_PAIRS-1:0]         type_o,
  output logic [NUM_PAIRS-1:0]           valid_o
);

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[i]  <= '0;
        type_o[i]  <= MT_UC;
        mask_o[i]  <= '0;
        valid_o[i] <= 1'b0;
      end else if (sel) begin
        if (wr_sel_mask_i) begin
          mask_o[i]  <= wr_data_i[PA_WIDTH-1:PAGE_LSB];
          valid_o[i] <= wr_data_i[VALID_BIT];
        end else begin
          base_o[i]  <= wr_data_i[PA_WIDTH-1:PAGE_LSB];
          type_o[i]  <= wr_data_i[7:0];
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (rd_idx_i == IDX_W'(i)) begin
        if (rd_sel_mask_i) begin
          rd_data_o[PA_WIDTH-1:PAGE_LSB] = mask_o[i];
          rd_data_o[VALID_BIT]           = valid_o[i];
        end else begin
          rd_data_o[PA_WIDTH-1:PAGE_LSB] = base_o[i];
          rd_data_o[7:0]                 = type_o[i];
        end
      end
    end
  end

endmodule

// File: rtl/vr_range_match.sv
module vr_range_match #(
  parameter int unsigned FW = 24
) (
  input  logic [FW-1:0] addr_i,
  input  logic [FW-1:0] base_i,
  input  logic [FW-1:0] mask_i,
  input  logic          valid_i,
  output logic          hit_o
);
  assign hit_o = valid_i && (((addr_i ^ base_i) & mask_i) == '0);
endmodule

// File: rtl/vr_type_merge.sv
module vr_type_merge
  import vr_mt_pkg::*;
#(
  parameter int unsigned NUM_PAIRS    = 6,
  parameter mtype_t      DEFAULT_TYPE = MT_UC
) (
  input  logic [NUM_PAIRS-1:0]   hit_i,
  input  mtype_t [NUM_PAIRS-1:0] type_i,
  output mtype_t                 type_o,
  output logic                   hit_o,
  output logic                   conflict_o
);

  mtype_t first_t;
  logic   found, any_uc, mixed, only_wbwt;

  always_comb begin
    first_t   = DEFAULT_TYPE;
    found     = 1'b0;
    any_uc    = 1'b0;
    mixed     = 1'b0;
    only_wbwt = 1'b1;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (hit_i[i]) begin
        if (!found) first_t = type_i[i];
        found = 1'b1;
      end
    end
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (hit_i[i]) begin
        if (type_i[i] == MT_UC) any_uc = 1'b1;
        if (type_i[i] != first_t) mixed = 1'b1;
        if (type_i[i] != MT_WB && type_i[i] != MT_WT) only_wbwt = 1'b0;
      end
    end
  end

  always_comb begin
    hit_o      = found;
    conflict_o = 1'b0;
    if (!found)         type_o = DEFAULT_TYPE;
    else if (any_uc)    type_o = MT_UC;
    else if (!mixed)    type_o = first_t;
    else if (only_wbwt) type_o = MT_WT;
    else begin
      type_o     = MT_UC;
      conflict_o = 1'b1;
    end
  end

endmodule

// File: rtl/vr_memtype_resolver.sv
module vr_memtype_resolver
  import vr_mt_pkg::*;
#(
  parameter int unsigned PA_WIDTH     = 36,
  parameter int unsigned NUM_PAIRS    = 6,
  parameter mtype_t      DEFAULT_TYPE = MT_UC,
  localparam int unsigned IDX_W       = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int unsigned FW          = PA_WIDTH - PAGE_LSB
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic                wr_sel_mask_i,
  input  logic [63:0]         wr_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  input  logic                rd_sel_mask_i,
  output logic [63:0]         rd_data_o,
  input  logic [PA_WIDTH-1:0] lk_addr_i,
  output logic [7:0]          mem_type_o,
  output logic                hit_o,
  output logic                conflict_o
);

  logic [NUM_PAIRS-1:0][FW-1:0] pair_base, pair_mask;
  mtype_t [NUM_PAIRS-1:0]       pair_type;
  logic [NUM_PAIRS-1:0]         pair_valid;
  logic [NUM_PAIRS-1:0]         pair_hit;
  mtype_t                       res_type;
  logic                         res_hit, res_conflict;

  vr_pair_regs #(
    .PA_WIDTH (PA_WIDTH),
    .NUM_PAIRS(NUM_PAIRS),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_sel_mask_i(wr_sel_mask_i),
    .wr_data_i    (wr_data_i),
    .rd_idx_i     (rd_idx_i),
    .rd_sel_mask_i(rd_sel_mask_i),
    .rd_data_o    (rd_data_o),
    .base_o       (pair_base),
    .mask_o       (pair_mask),
    .type_o       (pair_type),
    .valid_o      (pair_valid)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_match
    vr_range_match #(.FW(FW)) u_match (
      .addr_i (lk_addr_i[PA_WIDTH-1:PAGE_LSB]),
      .base_i (pair_base[i]),
      .mask_i (pair_mask[i]),
      .valid_i(pair_valid[i]),
      .hit_o  (pair_hit[i])
    );
  end

  vr_type_merge #(
    .NUM_PAIRS   (NUM_PAIRS),
    .DEFAULT_TYPE(DEFAULT_TYPE)
  ) u_merge (
    .hit_i     (pair_hit),
    .type_i    (pair_type),
    .type_o    (res_type),
    .hit_o     (res_hit),
    .conflict_o(res_conflict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_type_o <= DEFAULT_TYPE;
      hit_o      <= 1'b0;
      conflict_o <= 1'b0;
    end else begin
      mem_type_o <= res_type;
      hit_o      <= res_hit;
      conflict_o <= res_conflict;
    end
  end

endmodule

// File: rtl/vr_memtype_resolver_chk.sv
module vr_memtype_resolver_chk
  import vr_mt_pkg::*;
#(
  parameter int unsigned PA_WIDTH     = 36,
  parameter int unsigned NUM_PAIRS    = 6,
  parameter mtype_t      DEFAULT_TYPE = MT_UC
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [7:0]           mem_type_o,
  input logic                 hit_o,
  input logic                 conflict_o,
  input logic [63:0]          rd_data_o,
  input logic                 rd_sel_mask_i,
  input logic [NUM_PAIRS-1:0] pair_valid
);
  localparam logic [63:0] FIELD  = ((64'd1 << PA_WIDTH) - 64'd1) & ~64'hFFF;
  localparam logic [63:0] KEEP_B = FIELD | 64'hFF;
  localparam logic [63:0] KEEP_M = FIELD | (64'd1 << VALID_BIT);

  AST_CONFLICT_IS_UC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> (hit_o && mem_type_o == MT_UC)); // R5
  AST_MISS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (mem_type_o == DEFAULT_TYPE && !conflict_o)); // R6
  AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~(rd_sel_mask_i ? KEEP_M : KEEP_B)) == 64'd0); // R7
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(|pair_valid)); // R9
endmodule

bind vr_memtype_resolver vr_memtype_resolver_chk #(
  .PA_WIDTH    (PA_WIDTH),
  .NUM_PAIRS   (NUM_PAIRS),
  .DEFAULT_TYPE(DEFAULT_TYPE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_type_o   (mem_type_o),
  .hit_o        (hit_o),
  .conflict_o   (conflict_o),
  .rd_data_o    (rd_data_o),
  .rd_sel_mask_i(rd_sel_mask_i),
  .pair_valid   (pair_valid)
);

// File: tb/vr_memtype_resolver_test.sv
module vr_memtype_resolver_test;
  localparam int PA = 36;
  localparam int NP = 6;
  localparam int IW = 3;
  localparam logic [63:0] PAMAX = (64'd1 << PA) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic [PA-1:0] addr = '0;
  logic [7:0] mtype;
  logic hit, conf;

  int n_chk = 0, n_bad = 0;
  logic [63:0] m_start [NP];
  logic [63:0] m_size  [NP];
  logic [7:0]  m_type  [NP];
  logic        m_en    [NP];

  always #10 clk = ~clk;

  vr_memtype_resolver #(.PA_WIDTH(PA), .NUM_PAIRS(NP), .DEFAULT_TYPE(8'h00)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_sel_mask_i(wr_sel), .wr_data_i(wr_data), .rd_idx_i(rd_idx),
    .rd_sel_mask_i(rd_sel), .rd_data_o(rd_data), .lk_addr_i(addr),
    .mem_type_o(mtype), .hit_o(hit), .conflict_o(conf));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic sel, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(int idx, logic [63:0] start, logic [63:0] size, logic [7:0] t, logic en);
    m_start[idx] = start; m_size[idx] = size; m_type[idx] = t; m_en[idx] = en;
    wr(idx, 1'b0, (start & PAMAX) | {56'd0, t});
    wr(idx, 1'b1, (PAMAX & ~(size - 1)) | (64'(en) << 11));
  endtask

  // Independent model: interval test plus merge rules
  task automatic model(logic [63:0] a, output logic [7:0] t, output logic h, output logic c);
    bit uc = 0, wb = 0, wt = 0, other = 0;
    logic [7:0] ft = 8'h00;
    int cnt = 0;
    bit same = 1;
    for (int i = 0; i < NP; i++) begin
      if (m_en[i] && a >= m_start[i] && a < m_start[i] + m_size[i]) begin
        if (cnt == 0) ft = m_type[i];
        else if (m_type[i] != ft) same = 0;
        cnt++;
        case (m_type[i])
          8'h00: uc = 1;
          8'h06: wb = 1;
          8'h04: wt = 1;
          default: other = 1;
        endcase
      end
    end
    c = 0; h = (cnt > 0);
    if (cnt == 0) t = 8'h00;
    else if (uc) t = 8'h00;
    else if (same) t = ft;
    else if (!other && wb && wt) t = 8'h04;
    else begin t = 8'h00; c = 1; end
  endtask

  task automatic look(string req, logic [63:0] a);
    logic [7:0] et; logic eh, ec;
    @(negedge clk);
    addr = a[PA-1:0];
    model(a, et, eh, ec);
    @(negedge clk);
    chk({req, " type"}, 64'(mtype), 64'(et));
    chk({req, " hit"}, 64'(hit), 64'(eh));
    chk({req, " conflict"}, 64'(conf), 64'(ec));
  endtask

  task automatic sweep(string req, logic [63:0] lo, logic [63:0] hi, logic [63:0] step);
    for (logic [63:0] a = lo; a < hi; a += step) begin
      look(req, a);
      look(req, a + step - 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin m_en[i] = 0; m_start[i] = 0; m_size[i] = 4096; m_type[i] = 0; end
    #35;
    // R9: reset state
    chk("R9 hit", 64'(hit), 64'd0);
    chk("R9 type", 64'(mtype), 64'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < NP; i++) begin
      @(negedge clk); rd_idx = IW'(i); rd_sel = 1'b1; #1;
      chk("R9 mask readback", rd_data, 64'd0);
    end
    look("R9 no hit after reset", 64'h0);

    // R7: reserved bits dropped, field layout
    wr(5, 1'b0, '1);
    wr(5, 1'b1, '1);
    rd_idx = 3'd5; rd_sel = 1'b0; #1;
    chk("R7 base readback", rd_data, 64'hF_FFFF_F0FF);
    rd_sel = 1'b1; #1;
    chk("R7 mask readback", rd_data, 64'hF_FFFF_F800);
    wr(6, 1'b1, '1);
    rd_idx = 3'd6; #1;
    chk("R7 out-of-range index readback", rd_data, 64'd0);
    wr(5, 1'b1, 64'h0);

    // example layout: WB 0-64M, 64-96M, 96-100M; UC 64-68M, 15-16M; WC 8M at A0000000
    cfg(0, 64'h0,         64'h400_0000, 8'h06, 1);
    cfg(1, 64'h400_0000,  64'h200_0000, 8'h06, 1);
    cfg(2, 64'h600_0000,  64'h40_0000,  8'h06, 1);
    cfg(3, 64'h400_0000,  64'h40_0000,  8'h00, 1);
    cfg(4, 64'hF0_0000,   64'h10_0000,  8'h00, 1);
    cfg(5, 64'hA000_0000, 64'h80_0000,  8'h01, 1);
    rd_idx = 3'd2; rd_sel = 1'b1; #1;
    chk("R7 mask 4M", rd_data, 64'hF_FFC0_0800);

    // R1 R2 R3 R6: region edges and carve-outs
    sweep("R1/R3/R6 low", 64'h0, 64'h800_0000, 64'h8_0000);
    sweep("R1/R2 WC window", 64'h9FF0_0000, 64'hA090_0000, 64'h4_0000);
    look("R6 top of space", PAMAX);
    look("R1 last byte WB 96-100M", 64'h63F_FFFF);
    look("R1 first byte past 100M", 64'h640_0000);
    look("R3 UC inside WB", 64'h420_0000);

    // R8: back-to-back addresses, each result exactly one edge later
    @(negedge clk); addr = 36'h420_0000;
    @(negedge clk); chk("R8 pipe stage 1", 64'(mtype), 64'h00); addr = 36'hA000_0000;
    @(negedge clk); chk("R8 pipe stage 2", 64'(mtype), 64'h01); addr = 36'h800_0000;
    @(negedge clk); chk("R8 pipe stage 3", 64'(hit), 64'd0);

    // R4: WB+WT -> WT, WB+WB same type
    cfg(5, 64'h400_0000, 64'h200_0000, 8'h04, 1);
    sweep("R4 WB/WT overlap", 64'h380_0000, 64'h680_0000, 64'h10_0000);
    look("R4 WT over WB", 64'h500_0000);
    cfg(5, 64'h0, 64'h100_0000, 8'h06, 1);
    look("R4 WB over WB", 64'h80_0000);

    // R5: WC over WB conflicts
    cfg(5, 64'h200_0000, 64'h100_0000, 8'h01, 1);
    sweep("R5 WC/WB overlap", 64'h180_0000, 64'h380_0000, 64'h10_0000);
    look("R5 conflict", 64'h280_0000);

    // R1: disabling the UC carve-out exposes WB
    cfg(3, 64'h400_0000, 64'h40_0000, 8'h00, 0);
    look("R1 disabled pair ignored", 64'h420_0000);
    chk("R1 disabled pair type", 64'(mtype), 64'h06);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule